// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block decides, from sampled supply voltages, whether a backed-up rail is fed from the main supply or from a backup battery. It also write-protects an attached memory during a brownout and raises two warning flags. An external sampler delivers three unsigned millivolt codes: the main supply, the battery, and an auxiliary monitor input. A single-cycle qualifier marks each sample. All decision state changes only in a cycle where that qualifier is high.

The source selector is a two-state register with a hysteresis band around the battery code, which stops the output from chattering when the supply decays slowly. The supply-good flag compares the main supply against a reset threshold. The gated chip-enable is built from the live chip-enable input and the registered supply-good flag. The auxiliary flag reports a low auxiliary voltage, but only while the main supply is above the battery. Every threshold and the hysteresis offset are parameters. The defaults are 4500 mV reset, 10 mV hysteresis and 1300 mV auxiliary trip, on 13-bit codes.

Top module: `bkup_switch_ctrl`

## Requirements
- R1: After reset the outputs are: `on_battery` = 0 (main supply), `pwr_ok` = 0, `aux_low_n` = 1 and `ce_out_n` = 1.
- R2: While `pwr_ok` is 1, `ce_out_n` equals `ce_in_n` in the same cycle, with no register in between.
- R3: While `pwr_ok` is 0, `ce_out_n` is 1 whatever `ce_in_n` is.
- R4: One clock after a qualified sample, `pwr_ok` is 1 if the supply code is strictly greater than the reset threshold (default 4500). Otherwise it is 0, and a code equal to the threshold counts as a failure.
- R5: When on main (`on_battery` = 0), a qualified sample with supply + hysteresis <= battery switches `on_battery` to 1 on the next clock. The test is done in widened arithmetic, so a battery code below the hysteresis offset never causes a switch.
- R6: When on battery, a qualified sample with supply >= battery + hysteresis returns `on_battery` to 0 on the next clock. A sample strictly inside the band leaves it at 1. The sum is widened, so a battery code within the hysteresis of full scale keeps the battery selected.
- R7: One clock after a qualified sample, `aux_low_n` is 0 if the auxiliary code is below the trip level (default 1300) and the supply code is strictly greater than the battery code. Otherwise it is 1.
- R8: In a cycle with `sample_vld` = 0, `on_battery`, `pwr_ok` and `aux_low_n` keep their values whatever the codes carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | Qualifies the three codes in this cycle |
| vcc_mv | input | 13 | Main supply code, millivolts, unsigned |
| vbat_mv | input | 13 | Battery code, millivolts, unsigned |
| aux_mv | input | 13 | Auxiliary monitor code, millivolts, unsigned |
| ce_in_n | input | 1 | Active-low chip-enable from the address decoder |
| on_battery | output | 1 | 1 = backed-up rail fed from battery |
| ce_out_n | output | 1 | Active-low chip-enable to the memory, forced high in brownout |
| pwr_ok | output | 1 | 1 = supply above reset threshold; 0 = power fail |
| aux_low_n | output | 1 | 0 = auxiliary input below trip while supply above battery |

## Verification
The assertions assume that the codes only matter in cycles where `sample_vld` is high. They also assume that `ce_in_n` is a level the block may pass straight through. They make no assumption about how codes relate from one sample to the next, because supply and battery may jump arbitrarily. The stimulus changes inputs only at the falling clock edge and keeps codes within 13 bits. It walks the supply across the band edges one millivolt at a time, it places codes exactly on the reset and trip levels, and it drives codes near zero and near full scale to exercise the widened hysteresis arithmetic.

// File: rtl/bkup_pkg.sv
`timescale 1ns/1ps
package bkup_pkg;
   typedef enum logic {
      SRC_MAIN = 1'b0,
      SRC_BATT = 1'b1
   } src_e;
endpackage

// File: rtl/bkup_src_select.sv
`timescale 1ns/1ps
// Two-state source selector with a hysteresis band centred on the battery code.
module bkup_src_select
   import bkup_pkg::*;
#(
   parameter int CODE_W  = 13,
   parameter int HYST_MV = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [CODE_W-1:0] vcc,
   input  logic [CODE_W-1:0] vbat,
   output src_e              src
);
   localparam int EXT_W = CODE_W + 1;
   localparam logic [EXT_W-1:0] HYST_X = EXT_W'(HYST_MV);

   initial begin
      assert (HYST_MV > 0 && HYST_MV < (1 << CODE_W))
         else $error("bkup_src_select: HYST_MV out of range");
   end

   logic [EXT_W-1:0] vcc_x, vbat_x;
   logic             fall_trip, rise_trip;
   src_e             src_q, src_d;

   // widened sums: no wrap at either end of the code range
   assign vcc_x     = {1'b0, vcc};
   assign vbat_x    = {1'b0, vbat};
   assign fall_trip = (vcc_x + HYST_X) <= vbat_x;
   assign rise_trip = vcc_x >= (vbat_x + HYST_X);

   always_comb begin
      src_d = src_q;
      if (upd) begin
         unique case (src_q)
            SRC_MAIN: if (fall_trip) src_d = SRC_BATT;
            SRC_BATT: if (rise_trip) src_d = SRC_MAIN;
            default:  src_d = SRC_MAIN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= SRC_MAIN;
      else        src_q <= src_d;
   end

   assign src = src_q;

   // R8: no qualified sample, no change
   p_hold_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(src));
   // R5: falling supply crosses the lower band edge
   p_to_batt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && src == SRC_MAIN && ({1'b0, vcc} + HYST_X) <= {1'b0, vbat})
      |=> src == SRC_BATT);
   // R6: inside the band the battery stays selected
   p_no_chatter_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && src == SRC_BATT && {1'b0, vcc} < ({1'b0, vbat} + HYST_X))
      |=> src == SRC_BATT);
   // R6: rising supply crosses the upper band edge
   p_to_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && src == SRC_BATT && {1'b0, vcc} >= ({1'b0, vbat} + HYST_X))
      |=> src == SRC_MAIN);
endmodule

// File: rtl/bkup_level_flags.sv
`timescale 1ns/1ps
// Registered supply-good and auxiliary-low flags, updated on qualified samples.
module bkup_level_flags #(
   parameter int CODE_W      = 13,
   parameter int RESET_MV    = 4500,
   parameter int AUX_TRIP_MV = 1300
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [CODE_W-1:0] vcc,
   input  logic [CODE_W-1:0] vbat,
   input  logic [CODE_W-1:0] aux,
   output logic              sup_good,
   output logic              aux_low_n
);
   localparam logic [CODE_W-1:0] RESET_C = CODE_W'(RESET_MV);
   localparam logic [CODE_W-1:0] TRIP_C  = CODE_W'(AUX_TRIP_MV);

   initial begin
      assert (RESET_MV > 0 && RESET_MV < (1 << CODE_W))
         else $error("bkup_level_flags: RESET_MV out of range");
      assert (AUX_TRIP_MV > 0 && AUX_TRIP_MV < (1 << CODE_W))
         else $error("bkup_level_flags: AUX_TRIP_MV out of range");
   end

   logic good_q, auxn_q;
   logic above_rst, above_bat, aux_under;

   assign above_rst = vcc > RESET_C;
   assign above_bat = vcc > vbat;
   assign aux_under = aux < TRIP_C;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         good_q <= 1'b0;
         auxn_q <= 1'b1;
      end else if (upd) begin
         good_q <= above_rst;
         auxn_q <= !(aux_under && above_bat);
      end
   end

   assign sup_good  = good_q;
   assign aux_low_n = auxn_q;

   // R8: flags hold without a qualified sample
   p_hold_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> ($stable(sup_good) && $stable(aux_low_n)));
   // R4: a sample above the reset level yields supply good
   p_good_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && vcc > RESET_C) |=> sup_good);
   // R7: detector is inactive unless the supply is above the battery
   p_aux_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && vcc <= vbat) |=> aux_low_n);
endmodule

// File: rtl/bkup_ce_gate.sv
`timescale 1ns/1ps
// Write-protect gate: passes the active-low enable only while the supply is good.
module bkup_ce_gate (
   input  logic ce_in_n,
   input  logic sup_good,
   output logic ce_out_n
);
   assign ce_out_n = ce_in_n | ~sup_good;
endmodule

// File: rtl/bkup_switch_ctrl.sv
`timescale 1ns/1ps
module bkup_switch_ctrl
   import bkup_pkg::*;
#(
   parameter int CODE_W      = 13,
   parameter int RESET_MV    = 4500,
   parameter int HYST_MV     = 10,
   parameter int AUX_TRIP_MV = 1300
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_vld,
   input  logic [CODE_W-1:0] vcc_mv,
   input  logic [CODE_W-1:0] vbat_mv,
   input  logic [CODE_W-1:0] aux_mv,
   input  logic              ce_in_n,
   output logic              on_battery,
   output logic              ce_out_n,
   output logic              pwr_ok,
   output logic              aux_low_n
);
   initial begin
      assert (CODE_W >= 4 && CODE_W <= 24)
         else $error("bkup_switch_ctrl: CODE_W out of range");
   end

   src_e src;
   logic sup_good;

   bkup_src_select #(.CODE_W(CODE_W), .HYST_MV(HYST_MV)) u_sel (
      .clk(clk), .rst_n(rst_n), .upd(sample_vld),
      .vcc(vcc_mv), .vbat(vbat_mv), .src(src)
   );

   bkup_level_flags #(.CODE_W(CODE_W), .RESET_MV(RESET_MV),
                      .AUX_TRIP_MV(AUX_TRIP_MV)) u_flags (
      .clk(clk), .rst_n(rst_n), .upd(sample_vld),
      .vcc(vcc_mv), .vbat(vbat_mv), .aux(aux_mv),
      .sup_good(sup_good), .aux_low_n(aux_low_n)
   );

   bkup_ce_gate u_gate (
      .ce_in_n(ce_in_n), .sup_good(sup_good), .ce_out_n(ce_out_n)
   );

   assign on_battery = (src == SRC_BATT);
   assign pwr_ok     = sup_good;

   // R3: memory write-protected in brownout
   p_ce_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok |-> ce_out_n);
   // R2: an asserted enable passes while power is good
   p_ce_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_ok && !ce_in_n) |-> !ce_out_n);
endmodule

// File: tb/bkup_switch_ctrl_bench.sv
`timescale 1ns/1ps
module bkup_switch_ctrl_bench;
   localparam int W = 13;
   localparam int RST = 4500, HY = 10, TRIP = 1300;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sample_vld = 1'b0;
   logic [W-1:0] vcc_mv = '0, vbat_mv = '0, aux_mv = '0;
   logic ce_in_n = 1'b1;
   logic on_battery, ce_out_n, pwr_ok, aux_low_n;

   int n_vec = 0, n_bad = 0;
   // behavioural reference state
   int m_batt = 0, m_ok = 0, m_auxn = 1;

   always #2.5 clk = ~clk;

   bkup_switch_ctrl u_bkup_switch_ctrl (
      .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
      .vcc_mv(vcc_mv), .vbat_mv(vbat_mv), .aux_mv(aux_mv),
      .ce_in_n(ce_in_n), .on_battery(on_battery), .ce_out_n(ce_out_n),
      .pwr_ok(pwr_ok), .aux_low_n(aux_low_n)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R5|R6 on_battery", int'(on_battery), m_batt);
      chk("R4 pwr_ok", int'(pwr_ok), m_ok);
      chk("R7 aux_low_n", int'(aux_low_n), m_auxn);
      chk(m_ok ? "R2 ce_out_n" : "R3 ce_out_n", int'(ce_out_n),
          m_ok ? int'(ce_in_n) : 1);
   endtask

   // called at a falling edge: drive, check the pass-through, clock, check
   task automatic step(input bit vld, input int vcc, input int vbat,
                       input int aux, input bit ce);
      sample_vld = vld;
      vcc_mv  = W'(vcc);
      vbat_mv = W'(vbat);
      aux_mv  = W'(aux);
      ce_in_n = ce;
      #1;
      chk(m_ok ? "R2 ce_out_n live" : "R3 ce_out_n live", int'(ce_out_n),
          m_ok ? int'(ce) : 1);
      @(posedge clk);
      if (vld) begin
         if (m_batt == 0 && vcc + HY <= vbat) m_batt = 1;
         else if (m_batt == 1 && vcc >= vbat + HY) m_batt = 0;
         m_ok   = (vcc > RST) ? 1 : 0;
         m_auxn = (aux < TRIP && vcc > vbat) ? 0 : 1;
      end
      @(negedge clk);
      check_all();
   endtask

   initial begin : watchdog
      #500000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : stim
      int seed;
      repeat (3) @(negedge clk);
      // R1: reset state
      check_all();
      chk("R1 on_battery", int'(on_battery), 0);
      chk("R1 pwr_ok", int'(pwr_ok), 0);
      chk("R1 ce_out_n", int'(ce_out_n), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 / R2: good supply, enable passes both ways
      step(1, 5000, 3000, 2000, 0);
      step(0, 5000, 3000, 2000, 1);
      step(0, 5000, 3000, 2000, 0);
      // R4: exactly on the threshold is a failure; R3 blocks enable
      step(1, 4500, 3000, 2000, 0);
      step(1, 4501, 3000, 2000, 0);
      step(1, 4499, 3000, 2000, 0);
      // R8: unqualified codes that would flip everything are ignored
      step(0, 100, 6000, 10, 0);
      step(0, 6000, 100, 10, 0);
      // R5: walk down across the lower band edge
      step(1, 2995, 3000, 2000, 1);
      step(1, 2991, 3000, 2000, 1);
      step(1, 2990, 3000, 2000, 1);
      // R6: inside the band stays on battery, then crosses the upper edge
      step(1, 3005, 3000, 2000, 1);
      step(1, 3009, 3000, 2000, 1);
      step(1, 3010, 3000, 2000, 1);
      // R7: auxiliary trip boundaries and the supply-above-battery gate
      step(1, 5000, 3000, 1299, 0);
      step(1, 5000, 3000, 1300, 0);
      step(1, 3000, 3000, 1000, 0);
      step(1, 3001, 3000, 0, 0);
      // R5: battery below the hysteresis offset never switches
      step(1, 0, 5, 2000, 0);
      step(1, 0, 9, 2000, 0);
      step(1, 0, 10, 2000, 0);
      // R6: battery near full scale keeps battery selected
      step(1, 8000, 8190, 2000, 0);
      step(1, 8191, 8190, 2000, 0);
      step(1, 8191, 8181, 2000, 0);
      // mixed pattern, codes from a small congruential walk
      seed = 12345;
      for (int i = 0; i < 300; i++) begin
         int a, b, c;
         seed = (seed * 1103 + 12347) % 65521;
         a = seed % 8192;
         b = (i % 3 == 0) ? ((a + (seed % 25) - 12 + 8192) % 8192) : ((seed / 7) % 8192);
         c = (seed / 3) % 2600;
         step((seed % 4) != 0, a, b, c, (seed % 2) != 0);
      end
      // R1: reset in mid-run returns to the reset state
      rst_n = 1'b0;
      m_batt = 0; m_ok = 0; m_auxn = 1;
      #1;
      check_all();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule